// File: doc/BRIEF.md
# Serial Register Write Port

This block is a write-only serial target that loads a small register file. It has three serial inputs: an active-low select, a serial clock and a data line. All three are sampled in the system clock domain, and they are assumed to be already synchronised to it. While select is low, each rising edge of the serial clock shifts one data bit in, most significant bit first. Select must be low for the whole frame.

A frame is built from bytes in this order:
- The first byte is a fixed identification byte. It carries the seven-bit device code 1001111 followed by a 0 in the direction position.
- The second byte is the pointer byte. Bit 7 is the auto-increment flag and bits 6..0 give the register address.
- One or more data bytes follow.

Each complete data byte produces a single-cycle write strobe, together with the register address and the byte value. The pointer advances after each data byte when the flag is set, wrapping modulo 128, and stays put when the flag is clear. A frame with a wrong identification byte writes nothing. Raising select ends the frame at any point and drops any partial byte.

Top module: `spi_regwr_port`

## Requirements
- R1: After reset `wr_en` is 0 and no write is issued until a valid frame supplies a data byte.
- R2: The first byte of a frame must equal 0x9E (device code 1001111 in bits 7..1, direction bit 0 equal to 0). Any other first byte, including 0x9F, suppresses every write in that frame.
- R3: The second byte sets the register pointer from its bits 6..0 and the auto-increment flag from its bit 7.
- R4: Each data byte is taken MSB first on rising serial-clock edges and yields exactly one `wr_en` pulse, one system clock wide, with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R5: With the flag set, successive data bytes of one frame write consecutive addresses.
- R6: With the flag clear, every data byte of the frame writes the same address.
- R7: The pointer wraps modulo 128: an increment from address 0x7F gives 0x00.
- R8: Raising `cs_n` aborts the frame, clears the bit count and discards any partial byte. The next frame starts again with the identification byte.
- R9: Serial-clock edges while `cs_n` is high shift nothing in and issue no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdi | input | 1 | Serial data in |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 8 | Byte value of the write |

## Verification
The bench builds the block with its defaults: 8-bit bytes, device code 0x4F and the registered output stage. With these values the 0x7F-to-0x00 wrap can be reached in a two-byte burst, and the one-bit difference between the accepted header 0x9E and the read-direction header 0x9F is exercised. The serial clock runs at one eighth of the system clock, so every edge is seen clearly by the oversampler. Abort tests place the rise of `cs_n` both inside the header and inside a data byte.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
   typedef enum logic [1:0] {
      FR_HDR  = 2'd0,
      FR_PTR  = 2'd1,
      FR_DATA = 2'd2,
      FR_SKIP = 2'd3
   } frame_st_e;
endpackage

// File: rtl/spi_regwr_shifter.sv
module spi_regwr_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic              sclk_q;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] sr;
   logic [BYTE_W-1:0] sr_next;
   logic              rise;

   assign rise    = !cs_n && sclk && !sclk_q;
   assign sr_next = {sr[BYTE_W-2:0], sdi};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         bit_cnt  <= '0;
         sr       <= '0;
         byte_vld <= 1'b0;
         byte_val <= '0;
      end else begin
         sclk_q   <= sclk;
         byte_vld <= 1'b0;
         if (cs_n) begin
            bit_cnt <= '0;
            sr      <= '0;
         end else if (rise) begin
            sr <= sr_next;
            if (bit_cnt == LAST) begin
               bit_cnt  <= '0;
               byte_vld <= 1'b1;
               byte_val <= sr_next;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   AST_ABORT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> (bit_cnt == '0)); // R8
   AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld); // R4
endmodule

// File: rtl/spi_regwr_frame.sv
module spi_regwr_frame
   import spi_regwr_pkg::*;
#(
   parameter int                BYTE_W  = 8,
   parameter logic [BYTE_W-2:0] CHIP_ID = 7'h4F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_val,
   output logic              wr_req,
   output logic [BYTE_W-2:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data
);
   localparam int PTR_W = BYTE_W - 1;
   localparam logic [BYTE_W-1:0] HDR_CODE = {CHIP_ID, 1'b0};

   frame_st_e        st;
   logic [PTR_W-1:0] ptr;
   logic             inc_en;

   assign wr_req  = byte_vld && !cs_n && (st == FR_DATA);
   assign wr_addr = ptr;
   assign wr_data = byte_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= FR_HDR;
         ptr    <= '0;
         inc_en <= 1'b0;
      end else if (cs_n) begin
         st <= FR_HDR;
      end else if (byte_vld) begin
         unique case (st)
            FR_HDR:  st <= (byte_val == HDR_CODE) ? FR_PTR : FR_SKIP;
            FR_PTR: begin
               ptr    <= byte_val[PTR_W-1:0];
               inc_en <= byte_val[BYTE_W-1];
               st     <= FR_DATA;
            end
            FR_DATA: if (inc_en) ptr <= ptr + 1'b1;
            FR_SKIP: st <= FR_SKIP;
            default: st <= FR_SKIP;
         endcase
      end
   end

   AST_BAD_HDR_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !cs_n && st == FR_HDR && byte_val != HDR_CODE) |=> (st == FR_SKIP)); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && inc_en) |=> (ptr == PTR_W'($past(ptr) + 1'b1))); // R5
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !inc_en) |=> (ptr == $past(ptr))); // R6
   AST_IDLE_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (st == FR_HDR)); // R8
endmodule

// File: rtl/spi_regwr_port.sv
module spi_regwr_port #(
   parameter int                BYTE_W  = 8,
   parameter logic [BYTE_W-2:0] CHIP_ID = 7'h4F,
   parameter bit                OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              wr_en,
   output logic [BYTE_W-2:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data
);
   generate
      if (BYTE_W < 4) begin : g_bad_width
         $error("BYTE_W must be at least 4");
      end
   endgenerate

   logic              byte_vld;
   logic [BYTE_W-1:0] byte_val;
   logic              req_c;
   logic [BYTE_W-2:0] addr_c;
   logic [BYTE_W-1:0] data_c;

   spi_regwr_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .byte_vld(byte_vld), .byte_val(byte_val)
   );

   spi_regwr_frame #(.BYTE_W(BYTE_W), .CHIP_ID(CHIP_ID)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
      .byte_vld(byte_vld), .byte_val(byte_val),
      .wr_req(req_c), .wr_addr(addr_c), .wr_data(data_c)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_en   <= 1'b0;
               wr_addr <= '0;
               wr_data <= '0;
            end else begin
               wr_en <= req_c;
               if (req_c) begin
                  wr_addr <= addr_c;
                  wr_data <= data_c;
               end
            end
         end
      end else begin : g_out_comb
         assign wr_en   = req_c;
         assign wr_addr = addr_c;
         assign wr_data = data_c;
      end
   endgenerate

   AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R4
endmodule

// File: tb/spi_regwr_port_bench.sv
module spi_regwr_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       wr_en;
   logic [6:0] wr_addr;
   logic [7:0] wr_data;

   int checks = 0;
   int errors = 0;
   int log_n = 0;
   logic [6:0] log_addr [256];
   logic [7:0] log_data [256];

   always #4 clk = ~clk;

   spi_regwr_port u_spi_regwr_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always @(negedge clk) begin
      if (rst_n && wr_en && log_n < 256) begin
         log_addr[log_n] = wr_addr;
         log_data[log_n] = wr_data;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [7:0] b, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk) sdi = b[i];
         repeat (3) @(negedge clk);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic start_frame();
      @(negedge clk) cs_n = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic end_frame();
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic check_write(input int base, input int k, input logic [6:0] a,
                              input logic [7:0] d, input string req);
      chk(log_addr[base+k] == a, {req, " addr"}, log_addr[base+k], a);
      chk(log_data[base+k] == d, {req, " data"}, log_data[base+k], d);
   endtask

   task automatic test_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
      chk(log_n == 0, "R1 no write after reset", log_n, 0);
   endtask

   task automatic test_burst_inc();
      int base = log_n;
      start_frame();
      send_bits(8'h9E, 8);
      send_bits(8'h85, 8);
      send_bits(8'hA5, 8);
      send_bits(8'h3C, 8);
      send_bits(8'h01, 8);
      end_frame();
      chk(log_n - base == 3, "R4 one strobe per data byte", log_n - base, 3);
      check_write(base, 0, 7'h05, 8'hA5, "R3 pointer and MSB-first data");
      check_write(base, 1, 7'h06, 8'h3C, "R5 increment");
      check_write(base, 2, 7'h07, 8'h01, "R5 increment");
   endtask

   task automatic test_fixed_addr();
      int base = log_n;
      start_frame();
      send_bits(8'h9E, 8);
      send_bits(8'h12, 8);
      send_bits(8'h80, 8);
      send_bits(8'h7E, 8);
      end_frame();
      chk(log_n - base == 2, "R6 write count", log_n - base, 2);
      check_write(base, 0, 7'h12, 8'h80, "R6 fixed address");
      check_write(base, 1, 7'h12, 8'h7E, "R6 fixed address");
   endtask

   task automatic test_wrap();
      int base = log_n;
      start_frame();
      send_bits(8'h9E, 8);
      send_bits(8'hFF, 8);
      send_bits(8'h11, 8);
      send_bits(8'h22, 8);
      end_frame();
      chk(log_n - base == 2, "R7 write count", log_n - base, 2);
      check_write(base, 0, 7'h7F, 8'h11, "R7 top address");
      check_write(base, 1, 7'h00, 8'h22, "R7 wrap to zero");
   endtask

   task automatic test_bad_header();
      int base = log_n;
      start_frame();
      send_bits(8'h9F, 8);
      send_bits(8'h85, 8);
      send_bits(8'h5A, 8);
      end_frame();
      chk(log_n == base, "R2 direction bit set ignored", log_n - base, 0);
      start_frame();
      send_bits(8'h1E, 8);
      send_bits(8'h03, 8);
      send_bits(8'h9E, 8);
      send_bits(8'h44, 8);
      end_frame();
      chk(log_n == base, "R2 wrong device code ignored", log_n - base, 0);
   endtask

   task automatic test_abort();
      int base = log_n;
      start_frame();
      send_bits(8'h9E, 8);
      send_bits(8'h85, 8);
      send_bits(8'hF0, 4);
      end_frame();
      chk(log_n == base, "R8 partial data byte dropped", log_n - base, 0);
      start_frame();
      send_bits(8'hFF, 3);
      end_frame();
      start_frame();
      send_bits(8'h9E, 8);
      send_bits(8'h10, 8);
      send_bits(8'h3C, 8);
      end_frame();
      chk(log_n - base == 1, "R8 fresh frame after abort", log_n - base, 1);
      check_write(base, 0, 7'h10, 8'h3C, "R8 fresh frame after abort");
   endtask

   task automatic test_idle_clocks();
      int base = log_n;
      for (int i = 0; i < 13; i++) begin
         @(negedge clk) sdi = i[0];
         repeat (3) @(negedge clk);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      chk(log_n == base, "R9 idle clocks write nothing", log_n - base, 0);
      start_frame();
      send_bits(8'h9E, 8);
      send_bits(8'h2A, 8);
      send_bits(8'hC3, 8);
      end_frame();
      chk(log_n - base == 1, "R9 frame after idle clocks", log_n - base, 1);
      check_write(base, 0, 7'h2A, 8'hC3, "R9 frame after idle clocks");
   endtask

   initial begin
      fork
         begin
            test_reset();
            test_burst_inc();
            test_fixed_addr();
            test_wrap();
            test_bad_header();
            test_abort();
            test_idle_clocks();
         end
         begin
            repeat (200000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule